// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block covers one direction of a bridge between two parallel buses. Each request that arrives from the initiator bus is sorted by its 4-bit command code into one of three classes. A posted write is taken into an in-order write FIFO and acknowledged at once. A delayed write request (I/O or configuration write) is refused with retry and recorded in a small table. A delayed read request (any memory, I/O or configuration read) is handled the same way. Codes outside these classes are refused with retry and are not recorded.

A target-side issuer chooses the next transaction for the target bus. It takes the FIFO head or the lowest-indexed waiting table entry, and it alternates between the two classes when both have work. When a table entry completes on the target bus, its result is captured: the read data, or a zero status for a write. The result is handed back when the initiator repeats the identical request (same command, address and byte enables), and the entry is freed at that point. A read result is held back while any posted write that was queued before the result was captured is still in the FIFO. Writes are never merged, combined or collapsed.

Top module: `bto_order_queue`

## Requirements
- R1: Commands 0111 and 1111 are posted writes. When the FIFO has room they get response code ACCEPT (01) one cycle after the request.
- R2: Posted writes leave on the target bus strictly in acceptance order. Each one is issued on its own, including repeated writes to one address.
- R3: Commands 0011 and 1011 (delayed writes) and 0010, 0110, 1010, 1100 and 1110 (delayed reads) get RETRY (10) on a first attempt, and the request is recorded for issue.
- R4: A repeat of a recorded request whose target transfer has not finished gets RETRY. A delayed write reports completion only after it has been issued on the target bus.
- R5: A repeat that matches an entry on command, address and byte enables, once that entry has completed, gets DONE (11) with the captured read data (zero for a write). The entry is then freed.
- R6: A read completion is not returned while any posted write that was accepted before the completion was captured remains in the FIFO.
- R7: When both classes have work, the issuer alternates between them, so a posted write may go ahead of an earlier delayed request. After reset the posted class goes first.
- R8: A posted write that arrives while the 8-entry FIFO is full gets RETRY and is not recorded.
- R9: A new delayed request that arrives while all 4 table entries are in use gets RETRY and is not recorded.
- R10: Any other command code gets RETRY, and nothing is queued or issued for it.
- R11: During reset and right after it, rsp_valid and tgt_valid are low. A response appears exactly one cycle after each request and at no other time.
- R12: A transaction leaves the block only in a cycle where tgt_valid and tgt_ready are both high. It is then removed from the FIFO or marked complete in the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Initiator request present this cycle |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | AW | Request address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_code | output | 2 | 01 ACCEPT, 10 RETRY, 11 DONE |
| rsp_rdata | output | DW | Completion data with DONE, otherwise zero |
| tgt_valid | output | 1 | A transaction is offered to the target bus |
| tgt_cmd | output | 4 | Offered command |
| tgt_addr | output | AW | Offered address |
| tgt_be | output | 4 | Offered byte enables |
| tgt_wdata | output | DW | Offered write data |
| tgt_ready | input | 1 | Target completes the offered transaction |
| tgt_rdata | input | DW | Target read data, sampled with tgt_ready |

## Verification
Some rules can be checked on every cycle. The assertions cover these: the one-cycle request-to-response timing, ACCEPT for posted writes when the FIFO has room, RETRY when the FIFO is full and for unknown commands, and the FIFO occupancy bound. Other behaviour depends on history and only the bench scenarios can show it. This covers FIFO order without collapsing, the alternating issue order, the hold on a read completion behind older posted writes, entries freed by a matching repeat, and table overflow that leaves nothing recorded.

// File: rtl/bto_pkg.sv
package bto_pkg;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'b00,
    RSP_ACCEPT = 2'b01,
    RSP_RETRY  = 2'b10,
    RSP_DONE   = 2'b11
  } rsp_code_e;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'b00,
    CLS_POSTED = 2'b01,
    CLS_DWRITE = 2'b10,
    CLS_DREAD  = 2'b11
  } txn_class_e;

  function automatic txn_class_e bto_classify(input logic [3:0] cmd);
    case (cmd)
      4'b0111, 4'b1111:                            bto_classify = CLS_POSTED;
      4'b0011, 4'b1011:                            bto_classify = CLS_DWRITE;
      4'b0010, 4'b0110, 4'b1010, 4'b1100, 4'b1110: bto_classify = CLS_DREAD;
      default:                                     bto_classify = CLS_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/bto_post_fifo.sv
module bto_post_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [3:0]                   in_cmd,
  input  logic [AW-1:0]                in_addr,
  input  logic [3:0]                   in_be,
  input  logic [DW-1:0]                in_data,
  input  logic                         pop,
  output logic [3:0]                   head_cmd,
  output logic [AW-1:0]                head_addr,
  output logic [3:0]                   head_be,
  output logic [DW-1:0]                head_data,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 4 + AW + 4 + DW;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    nxt = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {in_cmd, in_addr, in_be, in_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      occ <= occ + 1'b1;
      else if (pop && !push) occ <= occ - 1'b1;
    end
  end

  assign {head_cmd, head_addr, head_be, head_data} = mem[rd_ptr];
  assign empty = (occ == '0);
  assign full  = (occ == CW'(DEPTH));
  assign count = occ;

endmodule

// File: rtl/bto_dly_table.sv
module bto_dly_table #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SLOTS  = 4,
  parameter int PDEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         lookup,
  input  logic [3:0]                   lk_cmd,
  input  logic [AW-1:0]                lk_addr,
  input  logic [3:0]                   lk_be,
  input  logic [DW-1:0]                lk_wdata,
  output logic                         deliver,
  output logic [DW-1:0]                deliver_data,
  input  logic                         take,
  input  logic [DW-1:0]                tgt_rdata,
  input  logic [$clog2(PDEPTH+1)-1:0]  post_count,
  input  logic                         post_pop,
  output logic                         pend_any,
  output logic [3:0]                   pend_cmd,
  output logic [AW-1:0]                pend_addr,
  output logic [3:0]                   pend_be,
  output logic [DW-1:0]                pend_wdata
);
  import bto_pkg::*;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW = $clog2(PDEPTH + 1);

  logic [SLOTS-1:0] vld, done;
  logic [3:0]       e_cmd   [SLOTS];
  logic [AW-1:0]    e_addr  [SLOTS];
  logic [3:0]       e_be    [SLOTS];
  logic [DW-1:0]    e_wdata [SLOTS];
  logic [DW-1:0]    e_rdata [SLOTS];
  logic [CW-1:0]    e_wait  [SLOTS];

  logic [SLOTS-1:0] match;
  logic             hit, free_any;
  logic [SW-1:0]    hit_idx, free_idx, pend_idx;

  for (genvar g = 0; g < SLOTS; g++) begin : g_match
    assign match[g] = vld[g] && (e_cmd[g] == lk_cmd) &&
                      (e_addr[g] == lk_addr) && (e_be[g] == lk_be);
  end

  always_comb begin
    hit = 1'b0;  hit_idx  = '0;
    free_any = 1'b0; free_idx = '0;
    pend_any = 1'b0; pend_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (match[i])            begin hit = 1'b1;      hit_idx  = SW'(i); end
      if (!vld[i])             begin free_any = 1'b1; free_idx = SW'(i); end
      if (vld[i] && !done[i])  begin pend_any = 1'b1; pend_idx = SW'(i); end
    end
  end

  assign deliver      = hit && done[hit_idx] && (e_wait[hit_idx] == '0);
  assign deliver_data = e_rdata[hit_idx];
  assign pend_cmd     = e_cmd[pend_idx];
  assign pend_addr    = e_addr[pend_idx];
  assign pend_be      = e_be[pend_idx];
  assign pend_wdata   = e_wdata[pend_idx];

  logic alloc;
  assign alloc = lookup && !hit && free_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      done <= '0;
    end else begin
      if (lookup && deliver) vld[hit_idx] <= 1'b0;
      if (alloc) begin
        vld[free_idx]  <= 1'b1;
        done[free_idx] <= 1'b0;
      end
      if (take) done[pend_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      e_cmd[free_idx]   <= lk_cmd;
      e_addr[free_idx]  <= lk_addr;
      e_be[free_idx]    <= lk_be;
      e_wdata[free_idx] <= lk_wdata;
    end
    for (int i = 0; i < SLOTS; i++) begin
      if (take && pend_idx == SW'(i)) begin
        if (bto_classify(e_cmd[i]) == CLS_DREAD) begin
          e_rdata[i] <= tgt_rdata;
          e_wait[i]  <= post_count;
        end else begin
          e_rdata[i] <= '0;
          e_wait[i]  <= '0;
        end
      end else if (post_pop && e_wait[i] != '0) begin
        e_wait[i] <= e_wait[i] - 1'b1;
      end
    end
  end

endmodule

// File: rtl/bto_issue_arb.sv
module bto_issue_arb (
  input  logic clk,
  input  logic rst,
  input  logic post_avail,
  input  logic dly_avail,
  input  logic tgt_ready,
  output logic sel_post,
  output logic issue_valid,
  output logic take_post,
  output logic take_dly
);
  logic last_post;

  assign sel_post    = post_avail && (!dly_avail || !last_post);
  assign issue_valid = post_avail || dly_avail;
  assign take_post   = issue_valid && tgt_ready && sel_post;
  assign take_dly    = issue_valid && tgt_ready && !sel_post;

  always_ff @(posedge clk) begin
    if (rst)                          last_post <= 1'b0;
    else if (issue_valid && tgt_ready) last_post <= sel_post;
  end

endmodule

// File: rtl/bto_order_queue.sv
module bto_order_queue #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int PDEPTH = 8,
  parameter int SLOTS  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [3:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  output logic [DW-1:0] rsp_rdata,
  output logic          tgt_valid,
  output logic [3:0]    tgt_cmd,
  output logic [AW-1:0] tgt_addr,
  output logic [3:0]    tgt_be,
  output logic [DW-1:0] tgt_wdata,
  input  logic          tgt_ready,
  input  logic [DW-1:0] tgt_rdata
);
  import bto_pkg::*;
  localparam int CW = $clog2(PDEPTH + 1);

  txn_class_e    cls;
  logic          is_post, is_dly;
  logic          post_push, post_pop, post_empty, post_full;
  logic [CW-1:0] post_count;
  logic [3:0]    ph_cmd, dh_cmd, ph_be, dh_be;
  logic [AW-1:0] ph_addr, dh_addr;
  logic [DW-1:0] ph_data, dh_data;
  logic          deliver, pend_any, sel_post, take_dly;
  logic [DW-1:0] deliver_data;

  assign cls       = bto_classify(req_cmd);
  assign is_post   = (cls == CLS_POSTED);
  assign is_dly    = (cls == CLS_DWRITE) || (cls == CLS_DREAD);
  assign post_push = req_valid && is_post && !post_full;

  bto_post_fifo #(.AW(AW), .DW(DW), .DEPTH(PDEPTH)) post_q (
    .clk(clk), .rst(rst), .push(post_push),
    .in_cmd(req_cmd), .in_addr(req_addr), .in_be(req_be), .in_data(req_wdata),
    .pop(post_pop),
    .head_cmd(ph_cmd), .head_addr(ph_addr), .head_be(ph_be), .head_data(ph_data),
    .empty(post_empty), .full(post_full), .count(post_count)
  );

  bto_dly_table #(.AW(AW), .DW(DW), .SLOTS(SLOTS), .PDEPTH(PDEPTH)) dly_t (
    .clk(clk), .rst(rst), .lookup(req_valid && is_dly),
    .lk_cmd(req_cmd), .lk_addr(req_addr), .lk_be(req_be), .lk_wdata(req_wdata),
    .deliver(deliver), .deliver_data(deliver_data),
    .take(take_dly), .tgt_rdata(tgt_rdata),
    .post_count(post_count), .post_pop(post_pop),
    .pend_any(pend_any), .pend_cmd(dh_cmd), .pend_addr(dh_addr),
    .pend_be(dh_be), .pend_wdata(dh_data)
  );

  bto_issue_arb arb (
    .clk(clk), .rst(rst), .post_avail(!post_empty), .dly_avail(pend_any),
    .tgt_ready(tgt_ready), .sel_post(sel_post), .issue_valid(tgt_valid),
    .take_post(post_pop), .take_dly(take_dly)
  );

  assign tgt_cmd   = sel_post ? ph_cmd  : dh_cmd;
  assign tgt_addr  = sel_post ? ph_addr : dh_addr;
  assign tgt_be    = sel_post ? ph_be   : dh_be;
  assign tgt_wdata = sel_post ? ph_data : dh_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_NONE;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= '0;
      if (!req_valid)
        rsp_code <= RSP_NONE;
      else if (is_post)
        rsp_code <= post_full ? RSP_RETRY : RSP_ACCEPT;
      else if (is_dly && deliver) begin
        rsp_code  <= RSP_DONE;
        rsp_rdata <= deliver_data;
      end else
        rsp_code <= RSP_RETRY;
    end
  end

endmodule

// File: rtl/bto_order_checker.sv
module bto_order_checker #(
  parameter int PDEPTH = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic [3:0]                  req_cmd,
  input logic                        rsp_valid,
  input logic [1:0]                  rsp_code,
  input logic                        post_full,
  input logic [$clog2(PDEPTH+1)-1:0] post_count
);
  import bto_pkg::*;

  assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid));

  assert_post_accept_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid && bto_classify(req_cmd) == CLS_POSTED && !post_full
    |=> rsp_valid && rsp_code == RSP_ACCEPT);

  assert_full_retry_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && bto_classify(req_cmd) == CLS_POSTED && post_full
    |=> rsp_valid && rsp_code == RSP_RETRY);

  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (rst)
    post_count <= ($clog2(PDEPTH+1))'(PDEPTH));

  assert_other_retry_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid && bto_classify(req_cmd) == CLS_OTHER
    |=> rsp_valid && rsp_code == RSP_RETRY);

endmodule

bind bto_order_queue bto_order_checker #(.PDEPTH(PDEPTH)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .post_full(post_full), .post_count(post_count)
);

// File: tb/bto_order_queue_tb.sv
module bto_order_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [DW-1:0] RD_MASK = 32'h5A5A_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, tgt_ready = 1'b0;
  logic [3:0] req_cmd = '0, req_be = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, tgt_valid;
  logic [1:0] rsp_code;
  logic [DW-1:0] rsp_rdata, tgt_wdata, tgt_rdata;
  logic [3:0] tgt_cmd, tgt_be;
  logic [AW-1:0] tgt_addr;

  int checks = 0, errors = 0;
  logic [DW+1:0]      exp_rsp[$];
  logic [4+AW+4+DW-1:0] exp_tgt[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tgt_rdata = tgt_addr ^ RD_MASK;

  bto_order_queue dut_i (.*);

  // monitor: compare produced results against the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_rsp.size() == 0) begin
        errors++; $display("FAIL rsp unexpected: got %b/%h expected none", rsp_code, rsp_rdata);
      end else begin
        logic [DW+1:0] e;
        e = exp_rsp.pop_front();
        if ({rsp_code, rsp_rdata} !== e) begin
          errors++;
          $display("FAIL rsp (R1/R3/R4/R5/R6/R8/R9/R10): got %b/%h expected %b/%h",
                   rsp_code, rsp_rdata, e[DW+1:DW], e[DW-1:0]);
        end
      end
    end
    if (!rst && tgt_valid && tgt_ready) begin
      checks++;
      if (exp_tgt.size() == 0) begin
        errors++; $display("FAIL tgt R12 unexpected issue: got %h/%h expected none", tgt_cmd, tgt_addr);
      end else begin
        logic [4+AW+4+DW-1:0] e;
        e = exp_tgt.pop_front();
        if ({tgt_cmd, tgt_addr, tgt_be, tgt_wdata} !== e) begin
          errors++;
          $display("FAIL tgt order (R2/R7/R12): got %h expected %h",
                   {tgt_cmd, tgt_addr, tgt_be, tgt_wdata}, e);
        end
      end
    end
  end

  task automatic send(input logic [3:0] c, input logic [AW-1:0] a, input logic [3:0] b,
                      input logic [DW-1:0] d, input logic [1:0] ec, input logic [DW-1:0] ed);
    @(posedge clk); #1;
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_be = b; req_wdata = d;
    exp_rsp.push_back({ec, ed});
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_issue(input logic [3:0] c, input logic [AW-1:0] a,
                              input logic [3:0] b, input logic [DW-1:0] d);
    exp_tgt.push_back({c, a, b, d});
  endtask

  task automatic pulse_ready(input int n);
    @(posedge clk); #1; tgt_ready = 1'b1;
    repeat (n) @(posedge clk);
    #1; tgt_ready = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    checks++;
    if (tgt_valid !== 1'b0) begin
      errors++; $display("FAIL %s idle: got tgt_valid=%b expected 0", tag, tgt_valid);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R11 reset state
    if (rsp_valid !== 1'b0 || tgt_valid !== 1'b0) begin
      errors++; $display("FAIL R11 reset: got %b%b expected 00", rsp_valid, tgt_valid);
    end
    @(posedge clk); #1; rst = 1'b0;

    // R1 R2: posted writes, two to the same address, no collapse
    send(4'b0111, 32'h1000, 4'hF, 32'hAAAA_0001, 2'b01, '0);
    send(4'b1111, 32'h1004, 4'h3, 32'hAAAA_0002, 2'b01, '0);
    send(4'b0111, 32'h1004, 4'hC, 32'hAAAA_0003, 2'b01, '0);
    expect_issue(4'b0111, 32'h1000, 4'hF, 32'hAAAA_0001);
    expect_issue(4'b1111, 32'h1004, 4'h3, 32'hAAAA_0002);
    expect_issue(4'b0111, 32'h1004, 4'hC, 32'hAAAA_0003);
    pulse_ready(4);
    check_idle("R2");

    // R3 R4 R5: delayed read, retried until completed, then data and free
    send(4'b0010, 32'h2000, 4'hF, '0, 2'b10, '0);
    send(4'b0010, 32'h2000, 4'hF, '0, 2'b10, '0);           // R4 not yet issued
    expect_issue(4'b0010, 32'h2000, 4'hF, '0);
    pulse_ready(1);
    send(4'b0010, 32'h2000, 4'hF, '0, 2'b11, 32'h2000 ^ RD_MASK); // R5
    check_idle("R5");

    // R6 R7: read parked, then two posted writes; posted goes first, read next
    send(4'b0110, 32'h3000, 4'hF, '0, 2'b10, '0);
    send(4'b0111, 32'h3100, 4'hF, 32'hBBBB_0001, 2'b01, '0);
    send(4'b0111, 32'h3104, 4'hF, 32'hBBBB_0002, 2'b01, '0);
    expect_issue(4'b0111, 32'h3100, 4'hF, 32'hBBBB_0001);   // R7 posted passes read
    expect_issue(4'b0110, 32'h3000, 4'hF, '0);               // R7 alternate
    pulse_ready(2);
    send(4'b0110, 32'h3000, 4'hF, '0, 2'b10, '0);           // R6 held behind write
    expect_issue(4'b0111, 32'h3104, 4'hF, 32'hBBBB_0002);
    pulse_ready(1);
    send(4'b0110, 32'h3000, 4'hF, '0, 2'b11, 32'h3000 ^ RD_MASK); // R6 released

    // R4 R5: delayed write completes only after target issue
    send(4'b1011, 32'h4000, 4'h1, 32'hCCCC_0001, 2'b10, '0);
    send(4'b1011, 32'h4000, 4'h1, 32'hCCCC_0001, 2'b10, '0);
    expect_issue(4'b1011, 32'h4000, 4'h1, 32'hCCCC_0001);
    pulse_ready(1);
    send(4'b1011, 32'h4000, 4'h2, 32'hCCCC_0001, 2'b10, '0); // R5 BE mismatch: new entry
    send(4'b1011, 32'h4000, 4'h1, 32'hCCCC_0001, 2'b11, '0);
    expect_issue(4'b1011, 32'h4000, 4'h2, 32'hCCCC_0001);
    pulse_ready(1);
    send(4'b1011, 32'h4000, 4'h2, 32'hCCCC_0001, 2'b11, '0);
    check_idle("R4");

    // R9: table full, fifth request not recorded
    send(4'b0010, 32'h5000, 4'hF, '0, 2'b10, '0);
    send(4'b0110, 32'h5004, 4'hF, '0, 2'b10, '0);
    send(4'b1010, 32'h5008, 4'hF, '0, 2'b10, '0);
    send(4'b1110, 32'h500C, 4'hF, '0, 2'b10, '0);
    send(4'b1100, 32'h5010, 4'hF, '0, 2'b10, '0);
    expect_issue(4'b0010, 32'h5000, 4'hF, '0);
    expect_issue(4'b0110, 32'h5004, 4'hF, '0);
    expect_issue(4'b1010, 32'h5008, 4'hF, '0);
    expect_issue(4'b1110, 32'h500C, 4'hF, '0);
    pulse_ready(6);
    check_idle("R9");
    send(4'b1110, 32'h500C, 4'hF, '0, 2'b11, 32'h500C ^ RD_MASK);
    send(4'b0010, 32'h5000, 4'hF, '0, 2'b11, 32'h5000 ^ RD_MASK);
    send(4'b1010, 32'h5008, 4'hF, '0, 2'b11, 32'h5008 ^ RD_MASK);
    send(4'b0110, 32'h5004, 4'hF, '0, 2'b11, 32'h5004 ^ RD_MASK);

    // R8: FIFO full, ninth write retried and dropped
    for (int i = 0; i < 8; i++) begin
      send(4'b0111, 32'h6000 + 32'(i*4), 4'hF, 32'hD000_0000 + 32'(i), 2'b01, '0);
      expect_issue(4'b0111, 32'h6000 + 32'(i*4), 4'hF, 32'hD000_0000 + 32'(i));
    end
    send(4'b1111, 32'h6100, 4'hF, 32'hDEAD_0009, 2'b10, '0);
    pulse_ready(10);
    check_idle("R8");

    // R10: unsupported command retried, nothing issued
    send(4'b0001, 32'h7000, 4'hF, 32'h1, 2'b10, '0);
    send(4'b0000, 32'h7004, 4'hF, 32'h2, 2'b10, '0);
    check_idle("R10");
    tgt_ready = 1'b1;
    check_idle("R10");
    tgt_ready = 1'b0;

    repeat (3) @(posedge clk);
    checks++;
    if (exp_rsp.size() != 0 || exp_tgt.size() != 0) begin
      errors++;
      $display("FAIL R11/R12 leftovers: got %0d/%0d expected 0/0", exp_rsp.size(), exp_tgt.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule